// File: doc/BRIEF.md
# Preset-Loaded Counter Channel

This block is a single up/down counter channel with a 24-bit count register and a 25th bit made from two toggle flags. Software reaches it through two byte-wide ports. A write to the control port is a command byte: its top three bits choose the target and its low five bits carry the payload. A write or read on the data port moves one byte of a multi-byte register. An internal byte pointer selects the byte and advances after each access. An external decoder supplies the count-enable and direction pulses.

Software never writes the count register directly. It fills the 24-bit preset register and then issues a command that copies the preset into the counter. Reads never look at the live count. A separate command snapshots the counter into a 24-bit output latch, and the data port drains that latch. Four count modes decide what happens at the ends of the range. Two of them use the preset value as the ceiling, and in every mode the floor is zero. A flag output pulses on an event chosen by the I/O control register: carry, compare, carry or borrow, or index.

Top module: `cnt_chan_top`

## Requirements
- R1: After reset the status byte reads 0x00, and a snapshot-and-read of the count returns 0.
- R2: Control bits 7:5 = 000 is a reset/load command. Bit 0 resets the byte pointer. Bits 4:3 = 01 copy the preset into the counter. Bits 4:3 = 10 copy the counter into the output latch. Data writes fill the preset and data reads drain the latch, each least significant byte first. One command may combine a pointer reset with a transfer.
- R3: The output latch changes only on a counter-to-latch command, so counting after a snapshot leaves the bytes that are read unchanged.
- R4: In normal mode (counter mode bits 2:1 = 00), counting up from 0xFFFFFF gives 0 and flips the carry toggle (status bit 1). Counting down from 0 gives 0xFFFFFF and flips the borrow toggle (status bit 0). Reported count bit 24 is the XOR of the two toggles. With flag source 00, a carry raises flag_out in the cycle the count wraps.
- R5: Status bit 5 is 1 after an up count and 0 after a down count.
- R6: In modulo-N mode (bits 2:1 = 11), counting up from the preset gives 0, and counting down from 0 gives the preset.
- R7: In range-limit mode (bits 2:1 = 01), the count holds at the preset when counting up and holds at 0 when counting down.
- R8: In non-recycle mode (bits 2:1 = 10), counting stops after a carry or borrow. It resumes only after the counter is loaded from the preset or cleared.
- R9: A high noise_in sets the error flag (status bit 4). A reset/load command with bits 2:1 = 11 clears it.
- R10: A reset/load command with bits 2:1 = 10 clears both toggle flags. Bits 2:1 = 01 clear the counter to 0.
- R11: The byte pointer stops after the third byte until it is reset. Further data writes are ignored, and data reads return 0x00.
- R12: Reset/load bits 4:3 = 11 copy the preset low byte to psc_out. Counter mode bits 4:3 drive quad_scale. Index control bit 0 drives idx_sync and bit 1 drives idx_pol.
- R13: I/O control bit 0 (target 010) enables counting. While it is 0, count pulses leave the count unchanged.
- R14: When I/O control bit 1 is 0, an index edge of the selected polarity (index control bit 1 = 1 means rising) loads the preset into the counter. With flag source 11 (I/O control bits 4:3), that edge also raises flag_out for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control port write strobe (command byte on wdata) |
| data_wr | input | 1 | Data port write strobe (preset byte on wdata) |
| data_rd | input | 1 | Data port read strobe, advances the byte pointer |
| wdata | input | 8 | Write data for both ports |
| cnt_en | input | 1 | Count pulse from the external decoder |
| cnt_up | input | 1 | Direction of the count pulse, 1 = up |
| index_in | input | 1 | Index input level |
| noise_in | input | 1 | Noise detected on the count inputs |
| rdata | output | 8 | Output latch byte at the byte pointer |
| status | output | 8 | Status byte: bit 0 borrow toggle, bit 1 carry toggle, bit 4 error, bit 5 up |
| flag_out | output | 1 | Registered pulse for the selected flag event |
| psc_out | output | 8 | Filter prescaler value |
| quad_scale | output | 2 | Quadrature scaling field |
| idx_sync | output | 1 | Synchronous index selection |
| idx_pol | output | 1 | Index polarity, 1 = positive |

## Verification
The assertions assume that at most one of ctl_wr, data_wr and data_rd is high in any cycle. They also assume that the index input changes only while no clear or load command is in progress. The stimulus drives each strobe for exactly one clock, one task at a time, and moves the index input only in its own scenario, with the other strobes idle. The properties for the mode limits and the wrap points leave out any cycle in which a clear, a load or an index load takes priority over the count pulse.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_RANGE  = 2'b01,
    MODE_NOREC  = 2'b10,
    MODE_MODN   = 2'b11
  } cmode_e;

  typedef enum logic [1:0] {
    FLG_CARRY  = 2'b00,
    FLG_CMP    = 2'b01,
    FLG_CYBW   = 2'b10,
    FLG_INDEX  = 2'b11
  } fsel_e;

  typedef struct packed {
    logic       bp_rst;
    logic       cnt_clr;
    logic       flg_clr;
    logic       err_clr;
    logic       ld_cnt;
    logic       ld_latch;
    logic       ld_psc;
    logic       wr_cmr;
    logic       wr_ior;
    logic       wr_idr;
    logic [4:0] payload;
  } cmd_t;
endpackage

// File: rtl/cnt_cmd_decode.sv
module cnt_cmd_decode
  import cnt_pkg::*;
(
  input  logic             ctl_wr,
  input  logic [BYTE_W-1:0] wdata,
  output cmd_t             cmd
);
  logic [2:0] tgt;
  logic       is_rld;

  assign tgt    = wdata[7:5];
  assign is_rld = ctl_wr && (tgt == 3'b000);

  always_comb begin
    cmd          = '0;
    cmd.payload  = wdata[4:0];
    cmd.bp_rst   = is_rld && wdata[0];
    cmd.cnt_clr  = is_rld && (wdata[2:1] == 2'b01);
    cmd.flg_clr  = is_rld && (wdata[2:1] == 2'b10);
    cmd.err_clr  = is_rld && (wdata[2:1] == 2'b11);
    cmd.ld_cnt   = is_rld && (wdata[4:3] == 2'b01);
    cmd.ld_latch = is_rld && (wdata[4:3] == 2'b10);
    cmd.ld_psc   = is_rld && (wdata[4:3] == 2'b11);
    cmd.wr_cmr   = ctl_wr && (tgt == 3'b001);
    cmd.wr_ior   = ctl_wr && (tgt == 3'b010);
    cmd.wr_idr   = ctl_wr && (tgt == 3'b011);
  end
endmodule

// File: rtl/cnt_byte_port.sv
module cnt_byte_port
  import cnt_pkg::*;
#(
  parameter int NBYTES = 3,
  localparam int CW    = NBYTES * BYTE_W,
  localparam int PW    = $clog2(NBYTES + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bp_rst,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              ld_latch,
  input  logic [CW-1:0]     cnt_val,
  output logic [CW-1:0]     preset_q,
  output logic [BYTE_W-1:0] rdata
);
  logic [PW-1:0] bp_q, bp_d;
  logic [CW-1:0] preset_d;
  logic [CW-1:0] latch_q, latch_d;
  logic          at_end;

  assign at_end = (bp_q == PW'(NBYTES));

  always_comb begin
    bp_d     = bp_q;
    preset_d = preset_q;
    latch_d  = latch_q;
    if (ld_latch) latch_d = cnt_val;
    if (bp_rst) begin
      bp_d = '0;
    end else if ((data_wr || data_rd) && !at_end) begin
      bp_d = bp_q + PW'(1);
    end
    if (data_wr && !at_end) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (bp_q == PW'(i)) preset_d[i*BYTE_W +: BYTE_W] = wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (bp_q == PW'(i)) rdata = latch_q[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q     <= '0;
      preset_q <= '0;
      latch_q  <= '0;
    end else begin
      bp_q     <= bp_d;
      preset_q <= preset_d;
      latch_q  <= latch_d;
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_latch |=> $stable(latch_q)); // R3
  AST_PTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && data_wr && !bp_rst) |=> $stable(preset_q)); // R11
endmodule

// File: rtl/cnt_core.sv
module cnt_core
  import cnt_pkg::*;
#(
  parameter int CW = 24
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          cnt_up,
  input  logic          ab_en,
  input  cmode_e        mode,
  input  logic [CW-1:0] preset,
  input  logic          cnt_clr,
  input  logic          ld_cnt,
  input  logic          idx_ld,
  input  logic          flg_clr,
  output logic [CW-1:0] cnt_q,
  output logic          bt_q,
  output logic          ct_q,
  output logic          ud_q,
  output logic          carry_ev,
  output logic          borrow_ev,
  output logic          cmp_ev
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_d;
  logic          bt_d, ct_d, ud_d, stop_q, stop_d, step;

  always_comb begin
    cnt_d     = cnt_q;
    bt_d      = bt_q;
    ct_d      = ct_q;
    ud_d      = ud_q;
    stop_d    = stop_q;
    carry_ev  = 1'b0;
    borrow_ev = 1'b0;
    step      = 1'b0;
    if (flg_clr) begin
      bt_d = 1'b0;
      ct_d = 1'b0;
    end
    if (cnt_clr) begin
      cnt_d  = '0;
      stop_d = 1'b0;
    end else if (ld_cnt || idx_ld) begin
      cnt_d  = preset;
      stop_d = 1'b0;
    end else if (cnt_en && ab_en && !stop_q) begin
      step = 1'b1;
      ud_d = cnt_up;
      if (cnt_up) begin
        unique case (mode)
          MODE_RANGE: begin
            if (cnt_q == preset) carry_ev = 1'b1;
            else cnt_d = cnt_q + 1'b1;
          end
          MODE_MODN: begin
            if (cnt_q == preset) begin
              carry_ev = 1'b1;
              cnt_d    = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
          default: begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == CMAX) carry_ev = 1'b1;
          end
        endcase
      end else begin
        unique case (mode)
          MODE_RANGE: begin
            if (cnt_q == '0) borrow_ev = 1'b1;
            else cnt_d = cnt_q - 1'b1;
          end
          MODE_MODN: begin
            if (cnt_q == '0) begin
              borrow_ev = 1'b1;
              cnt_d     = preset;
            end else cnt_d = cnt_q - 1'b1;
          end
          default: begin
            cnt_d = cnt_q - 1'b1;
            if (cnt_q == '0) borrow_ev = 1'b1;
          end
        endcase
      end
      if (carry_ev) ct_d = ~ct_q;
      if (borrow_ev) bt_d = ~bt_q;
      if ((mode == MODE_NOREC) && (carry_ev || borrow_ev)) stop_d = 1'b1;
    end
  end

  assign cmp_ev = step && (cnt_d == preset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bt_q   <= 1'b0;
      ct_q   <= 1'b0;
      ud_q   <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bt_q   <= bt_d;
      ct_q   <= ct_d;
      ud_q   <= ud_d;
      stop_q <= stop_d;
    end
  end

  AST_NORMAL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NORMAL && cnt_en && ab_en && cnt_up && cnt_q == CMAX &&
     !cnt_clr && !ld_cnt && !idx_ld) |=> (cnt_q == '0)); // R4
  AST_CARRY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_ev && !flg_clr) |=> (ct_q != $past(ct_q))); // R4
  AST_MODN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MODN && cnt_en && ab_en && cnt_up && cnt_q == preset &&
     !stop_q && !cnt_clr && !ld_cnt && !idx_ld) |=> (cnt_q == '0)); // R6
  AST_RANGE_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RANGE && cnt_up && cnt_q == preset &&
     !cnt_clr && !ld_cnt && !idx_ld) |=> $stable(cnt_q)); // R7
  AST_NOREC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !cnt_clr && !ld_cnt && !idx_ld) |=> $stable(cnt_q)); // R8
  AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_en && !cnt_clr && !ld_cnt && !idx_ld) |=> $stable(cnt_q)); // R13
endmodule

// File: rtl/cnt_chan_top.sv
module cnt_chan_top
  import cnt_pkg::*;
#(
  parameter int NBYTES = 3,
  localparam int CW    = NBYTES * BYTE_W
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        data_wr,
  input  logic        data_rd,
  input  logic [7:0]  wdata,
  input  logic        cnt_en,
  input  logic        cnt_up,
  input  logic        index_in,
  input  logic        noise_in,
  output logic [7:0]  rdata,
  output logic [7:0]  status,
  output logic        flag_out,
  output logic [7:0]  psc_out,
  output logic [1:0]  quad_scale,
  output logic        idx_sync,
  output logic        idx_pol
);
  cmd_t          cmd;
  logic [CW-1:0] preset, cnt_val;
  logic          bt, ct, ud, carry_ev, borrow_ev, cmp_ev;

  cmode_e        mode_q, mode_d;
  logic [1:0]    scale_q, scale_d;
  logic          ab_en_q, ab_en_d, pidx_n_q, pidx_n_d;
  fsel_e         fsel_q, fsel_d;
  logic          sync_q, sync_d, pol_q, pol_d;
  logic [7:0]    psc_q, psc_d;
  logic          err_q, err_d, idx_q, flag_q, flag_d;
  logic          idx_edge, idx_ld;

  cnt_cmd_decode u_dec (
    .ctl_wr (ctl_wr),
    .wdata  (wdata),
    .cmd    (cmd)
  );

  cnt_byte_port #(.NBYTES(NBYTES)) u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .bp_rst   (cmd.bp_rst),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .wdata    (wdata),
    .ld_latch (cmd.ld_latch),
    .cnt_val  (cnt_val),
    .preset_q (preset),
    .rdata    (rdata)
  );

  assign idx_edge = pol_q ? (index_in && !idx_q) : (!index_in && idx_q);
  assign idx_ld   = idx_edge && !pidx_n_q;

  cnt_core #(.CW(CW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .cnt_up    (cnt_up),
    .ab_en     (ab_en_q),
    .mode      (mode_q),
    .preset    (preset),
    .cnt_clr   (cmd.cnt_clr),
    .ld_cnt    (cmd.ld_cnt),
    .idx_ld    (idx_ld),
    .flg_clr   (cmd.flg_clr),
    .cnt_q     (cnt_val),
    .bt_q      (bt),
    .ct_q      (ct),
    .ud_q      (ud),
    .carry_ev  (carry_ev),
    .borrow_ev (borrow_ev),
    .cmp_ev    (cmp_ev)
  );

  always_comb begin
    mode_d   = mode_q;
    scale_d  = scale_q;
    ab_en_d  = ab_en_q;
    pidx_n_d = pidx_n_q;
    fsel_d   = fsel_q;
    sync_d   = sync_q;
    pol_d    = pol_q;
    psc_d    = psc_q;
    err_d    = err_q;
    if (cmd.wr_cmr) begin
      mode_d  = cmode_e'(cmd.payload[2:1]);
      scale_d = cmd.payload[4:3];
    end
    if (cmd.wr_ior) begin
      ab_en_d  = cmd.payload[0];
      pidx_n_d = cmd.payload[1];
      fsel_d   = fsel_e'(cmd.payload[4:3]);
    end
    if (cmd.wr_idr) begin
      sync_d = cmd.payload[0];
      pol_d  = cmd.payload[1];
    end
    if (cmd.ld_psc) psc_d = preset[7:0];
    if (cmd.err_clr) err_d = 1'b0;
    if (noise_in) err_d = 1'b1;
    unique case (fsel_q)
      FLG_CARRY: flag_d = carry_ev;
      FLG_CMP:   flag_d = cmp_ev;
      FLG_CYBW:  flag_d = carry_ev || borrow_ev;
      default:   flag_d = idx_edge;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_NORMAL;
      scale_q  <= 2'b00;
      ab_en_q  <= 1'b0;
      pidx_n_q <= 1'b0;
      fsel_q   <= FLG_CARRY;
      sync_q   <= 1'b0;
      pol_q    <= 1'b0;
      psc_q    <= '0;
      err_q    <= 1'b0;
      idx_q    <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      scale_q  <= scale_d;
      ab_en_q  <= ab_en_d;
      pidx_n_q <= pidx_n_d;
      fsel_q   <= fsel_d;
      sync_q   <= sync_d;
      pol_q    <= pol_d;
      psc_q    <= psc_d;
      err_q    <= err_d;
      idx_q    <= index_in;
      flag_q   <= flag_d;
    end
  end

  assign status     = {2'b00, ud, err_q, 2'b00, ct, bt};
  assign flag_out   = flag_q;
  assign psc_out    = psc_q;
  assign quad_scale = scale_q;
  assign idx_sync   = sync_q;
  assign idx_pol    = pol_q;

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    noise_in |=> status[4]); // R9
  AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.err_clr && !noise_in) |=> !status[4]); // R9
  AST_FLG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.flg_clr && !cnt_en) |=> (status[1:0] == 2'b00)); // R10
  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_ld && !cmd.cnt_clr) |=> (cnt_val == $past(preset))); // R14
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_wr, data_wr, data_rd})); // R2
endmodule

// File: tb/tb_cnt_chan_top.sv
module tb_cnt_chan_top;
  localparam int CLK_P = 10;

  logic       clk, rst_n, ctl_wr, data_wr, data_rd, cnt_en, cnt_up, index_in, noise_in;
  logic [7:0] wdata, rdata, status, psc_out;
  logic       flag_out, idx_sync, idx_pol;
  logic [1:0] quad_scale;
  int         nchk, nfail;
  bit         done;

  cnt_chan_top dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .data_wr(data_wr), .data_rd(data_rd),
    .wdata(wdata), .cnt_en(cnt_en), .cnt_up(cnt_up), .index_in(index_in),
    .noise_in(noise_in), .rdata(rdata), .status(status), .flag_out(flag_out),
    .psc_out(psc_out), .quad_scale(quad_scale), .idx_sync(idx_sync), .idx_pol(idx_pol)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] b);
    @(negedge clk); wdata = b; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic dwr(input logic [7:0] b);
    @(negedge clk); wdata = b; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic drd(output logic [7:0] b);
    @(negedge clk); b = rdata; data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic read_cnt(output logic [24:0] v);
    logic [7:0] b0, b1, b2;
    ctl(8'h11);
    drd(b0); drd(b1); drd(b2);
    v = {status[0] ^ status[1], b2, b1, b0};
  endtask

  task automatic set_preset(input logic [23:0] v);
    ctl(8'h01);
    dwr(v[7:0]); dwr(v[15:8]); dwr(v[23:16]);
  endtask

  task automatic load(input logic [23:0] v);
    set_preset(v);
    ctl(8'h08);
  endtask

  task automatic pulse(input logic up, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cnt_en = 1'b1; cnt_up = up;
      @(negedge clk); cnt_en = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [24:0] v;
    check("R1 status", status, 8'h00);
    read_cnt(v);
    check("R1 count", v, 25'h0);
  endtask

  task automatic t_load;
    logic [24:0] v;
    load(24'h123456);
    read_cnt(v);
    check("R2 load/read", v, 25'h0123456);
  endtask

  task automatic t_latch;
    logic [7:0] b0, b1, b2;
    logic [24:0] v;
    ctl(8'h10);
    pulse(1'b1, 3);
    ctl(8'h01);
    drd(b0); drd(b1); drd(b2);
    check("R3 latch held", {b2, b1, b0}, 24'h123456);
    read_cnt(v);
    check("R3 new snapshot", v, 25'h0123459);
    check("R5 up dir", status[5], 1'b1);
    pulse(1'b0, 1);
    check("R5 down dir", status[5], 1'b0);
  endtask

  task automatic t_wrap;
    logic [24:0] v;
    ctl(8'h20);
    load(24'hFFFFFF);
    ctl(8'h04);
    pulse(1'b1, 1);
    check("R4 carry flag_out", flag_out, 1'b1);
    read_cnt(v);
    check("R4 up wrap", v, 25'h1000000);
    pulse(1'b0, 1);
    read_cnt(v);
    check("R4 down wrap", v, 25'h0FFFFFF);
    check("R4 toggles", status[1:0], 2'b11);
  endtask

  task automatic t_clear;
    logic [24:0] v;
    ctl(8'h04);
    check("R10 flags clear", status[1:0], 2'b00);
    ctl(8'h02);
    read_cnt(v);
    check("R10 counter clear", v, 25'h0);
  endtask

  task automatic t_modn;
    logic [24:0] v;
    ctl(8'h26);
    load(24'd5);
    pulse(1'b1, 1);
    read_cnt(v);
    check("R6 up wrap", v[23:0], 24'd0);
    pulse(1'b0, 1);
    read_cnt(v);
    check("R6 down wrap", v[23:0], 24'd5);
  endtask

  task automatic t_range;
    logic [24:0] v;
    ctl(8'h22);
    load(24'd5);
    pulse(1'b1, 2);
    read_cnt(v);
    check("R7 hold ceiling", v[23:0], 24'd5);
    ctl(8'h02);
    pulse(1'b0, 1);
    read_cnt(v);
    check("R7 hold floor", v[23:0], 24'd0);
    pulse(1'b1, 2);
    read_cnt(v);
    check("R7 counts up", v[23:0], 24'd2);
  endtask

  task automatic t_norec;
    logic [24:0] v;
    ctl(8'h24);
    load(24'hFFFFFE);
    pulse(1'b1, 2);
    pulse(1'b1, 3);
    read_cnt(v);
    check("R8 stopped", v[23:0], 24'd0);
    load(24'd7);
    pulse(1'b1, 1);
    read_cnt(v);
    check("R8 resumed", v[23:0], 24'd8);
  endtask

  task automatic t_err;
    @(negedge clk); noise_in = 1'b1;
    @(negedge clk); noise_in = 1'b0;
    check("R9 error set", status[4], 1'b1);
    ctl(8'h06);
    check("R9 error clear", status[4], 1'b0);
  endtask

  task automatic t_ptr;
    logic [24:0] v;
    logic [7:0]  b;
    ctl(8'h01);
    dwr(8'h11); dwr(8'h22); dwr(8'h33); dwr(8'h44);
    ctl(8'h08);
    read_cnt(v);
    check("R11 fourth write ignored", v[23:0], 24'h332211);
    drd(b);
    check("R11 read past end", b, 8'h00);
  endtask

  task automatic t_psc;
    ctl(8'h01);
    dwr(8'h5A);
    ctl(8'h18);
    check("R12 prescaler", psc_out, 8'h5A);
    ctl(8'h38);
    check("R12 scale", quad_scale, 2'b11);
    ctl(8'h63);
    check("R12 idx fields", {idx_sync, idx_pol}, 2'b11);
  endtask

  task automatic t_enable;
    logic [24:0] v0, v1;
    ctl(8'h42);
    read_cnt(v0);
    pulse(1'b1, 3);
    read_cnt(v1);
    check("R13 disabled hold", v1, v0);
  endtask

  task automatic t_index;
    logic [24:0] v;
    ctl(8'h59);
    ctl(8'h62);
    set_preset(24'h000777);
    ctl(8'h02);
    @(negedge clk); index_in = 1'b1;
    @(negedge clk);
    check("R14 index flag", flag_out, 1'b1);
    @(negedge clk);
    check("R14 flag one cycle", flag_out, 1'b0);
    index_in = 1'b0;
    read_cnt(v);
    check("R14 index load", v[23:0], 24'h000777);
  endtask

  initial begin
    nchk = 0; nfail = 0; done = 1'b0;
    rst_n = 1'b0; ctl_wr = 0; data_wr = 0; data_rd = 0; wdata = 0;
    cnt_en = 0; cnt_up = 0; index_in = 0; noise_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    ctl(8'h43);
    t_load;
    t_latch;
    t_wrap;
    t_clear;
    t_modn;
    t_range;
    t_norec;
    t_err;
    t_ptr;
    t_psc;
    t_enable;
    t_index;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule